// File: doc/BRIEF.md
# Line-Sync Presence Detector

This block decides whether an external line-rate sync signal is present. Once per line period a sampling strobe arrives, together with a flag saying whether a sync pulse was seen during that line. Two saturating run counters track the current run of lines with sync and the current run of lines without it. A two-state machine raises the presence flag when the run of seen lines reaches the acquire length, and drops it when the run of missed lines reaches the loss length. Because the two lengths are set separately, the flag has asymmetric hysteresis.

Both lengths, and three output-control fields, are loaded by a two-byte command on a byte-wide write port. A second two-state machine handles the byte sequence. In `CMD_IDLE` a byte carrying the command identifier in its upper nibble loads the control fields and takes the transition to `CMD_WAIT2`. In `CMD_WAIT2` a byte with bit 7 clear is taken as the threshold byte and returns the machine to `CMD_IDLE`. A byte there with a matching identifier restarts the sequence and the machine stays in `CMD_WAIT2`. Any other byte leaves it waiting. The presence machine moves from `PR_ABSENT` to `PR_PRESENT` on acquisition and from `PR_PRESENT` to `PR_ABSENT` on loss. Sync separation and the analog video path are outside this block, which only drives their control bits.

Top module: `sync_presence_top`

## Requirements
- R1: While reset is asserted the presence flag, the pin source, the line-count select and the mute all read 0. Reset also clears both threshold codes to 0.
- R2: A first byte is one whose bits 7:4 equal the identifier (default 4'hC). From the cycle after it is written, it sets the pin source from bits 3:2 (00 separated sync, 01 low, 10 high, 11 timing pulse), the line-count select from bit 1 (1 means 10 lines) and the mute from bit 0.
- R3: In `CMD_IDLE`, a byte with a non-matching identifier changes no control output and no threshold. This holds even when its bit 7 is 0.
- R4: The threshold byte is accepted only in `CMD_WAIT2` and only with bit 7 clear. Its bits 6:4 give the acquire code and bits 3:0 give the loss code. In `CMD_WAIT2`, a byte with bit 7 set and a non-matching identifier is ignored and the machine keeps waiting.
- R5: Acquire codes 001, 010 and 100 need 4, 8 and 16 consecutive seen strobes. The flag rises in the cycle after the strobe that completes the run, and not one strobe earlier.
- R6: With acquire code 000, a low flag rises on the next clock edge with no strobe needed.
- R7: Loss codes 0001, 0010, 0100 and 1000 drop a high flag after 32, 64, 128 and 256 consecutive missed strobes. The flag falls in the cycle after the completing strobe.
- R8: With loss code 0000 the flag never falls, however many strobes are missed.
- R9: A missed strobe restarts the seen run, and a seen strobe restarts the missed run.
- R10: A threshold field that is neither zero nor one-hot leaves that threshold unchanged. The other field of the same byte is still applied.
- R11: Both run counters saturate instead of wrapping, and they keep counting whatever the flag state or threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | One-cycle pulse per line period |
| sync_seen | input | 1 | Sync pulse observed in this line; sampled only with the strobe |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| sync_present | output | 1 | Presence flag |
| pin_src | output | 2 | Output-pin source select |
| ten_lines | output | 1 | 1 selects 10 displayed lines, 0 selects 12 |
| video_mute | output | 1 | Cut video input and hold output at pedestal |

## Verification
The hardest case to reach is counter saturation. It only shows once a run exceeds the counter range, and only when a threshold is enabled afterwards. The stimulus turns loss detection off, applies 600 misses so the missed-run counter sits at its ceiling, and then loads a 256-line loss length. A single further miss must then drop the flag, which a wrapped counter would not do. Commands that must be ignored are checked by following them with strobe runs that would end differently had they been accepted.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

    typedef enum logic [1:0] {
        SRC_SEPARATED = 2'b00,
        SRC_LOW       = 2'b01,
        SRC_HIGH      = 2'b10,
        SRC_PULSE     = 2'b11
    } pin_src_e;

    typedef enum logic {
        CMD_IDLE,
        CMD_WAIT2
    } cmd_state_e;

    typedef enum logic {
        PR_ABSENT,
        PR_PRESENT
    } pr_state_e;

    typedef struct packed {
        pin_src_e src;
        logic     ten_lines;
        logic     mute;
    } ctrl_t;

endpackage

// File: rtl/sync_cmd_decoder.sv
module sync_cmd_decoder
    import sync_det_pkg::*;
#(
    parameter logic [3:0] CMD_ID = 4'hC,
    parameter int         ACQ_W  = 3,
    parameter int         LOSS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output ctrl_t             ctrl,
    output logic [ACQ_W-1:0]  acq_code,
    output logic [LOSS_W-1:0] loss_code
);
    localparam int ACQ_LSB = 4;

    cmd_state_e        state, state_nx;
    logic              id_hit;
    logic              take_first;
    logic              take_second;
    logic [ACQ_W-1:0]  acq_field;
    logic [LOSS_W-1:0] loss_field;
    logic              acq_ok;
    logic              loss_ok;

    always_comb begin
        id_hit      = (wr_data[7:4] == CMD_ID);
        acq_field   = wr_data[ACQ_LSB +: ACQ_W];
        loss_field  = wr_data[LOSS_W-1:0];
        acq_ok      = ((acq_field & (acq_field - ACQ_W'(1))) == '0);
        loss_ok     = ((loss_field & (loss_field - LOSS_W'(1))) == '0);
        take_first  = wr_en && id_hit;
        take_second = wr_en && (state == CMD_WAIT2) && !id_hit && !wr_data[7];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            CMD_IDLE: begin
                if (take_first) state_nx = CMD_WAIT2;
            end
            CMD_WAIT2: begin
                if (take_first)       state_nx = CMD_WAIT2;
                else if (take_second) state_nx = CMD_IDLE;
            end
            default: state_nx = CMD_IDLE;
        endcase
    end

    // control and threshold registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            acq_code  <= '0;
            loss_code <= '0;
        end else begin
            if (take_first) begin
                ctrl.src       <= pin_src_e'(wr_data[3:2]);
                ctrl.ten_lines <= wr_data[1];
                ctrl.mute      <= wr_data[0];
            end
            if (take_second) begin
                if (acq_ok)  acq_code  <= acq_field;
                if (loss_ok) loss_code <= loss_field;
            end
        end
    end

    AST_CODES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (((acq_code & (acq_code - ACQ_W'(1))) == '0) && ((loss_code & (loss_code - LOSS_W'(1))) == '0))); // R10
    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == CMD_IDLE && wr_data[7:4] != CMD_ID) |=> (state == CMD_IDLE && $stable(ctrl) && $stable(acq_code) && $stable(loss_code))); // R3
    AST_SECOND_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == CMD_IDLE && !$stable(loss_code)) |-> 1'b0); // R4

endmodule

// File: rtl/sync_run_counter.sv
module sync_run_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (clr)                      cnt <= '0;
        else if (inc && cnt != CNT_MAX)    cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && inc && !clr) |=> (cnt == CNT_MAX)); // R11
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R9

endmodule

// File: rtl/sync_thr_decode.sv
module sync_thr_decode #(
    parameter int CODE_W = 3,
    parameter int SHIFT  = 2,
    parameter int LEN_W  = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);
    logic [LEN_W-1:0] term [CODE_W];

    for (genvar g = 0; g < CODE_W; g++) begin : g_term
        assign term[g] = code[g] ? (LEN_W'(1) << (g + SHIFT)) : '0;
    end

    always_comb begin
        len = '0;
        for (int i = 0; i < CODE_W; i++) len = len | term[i];
    end

endmodule

// File: rtl/sync_presence_fsm.sv
module sync_presence_fsm
    import sync_det_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             seen,
    input  logic [CNT_W-1:0] hit_cnt,
    input  logic [CNT_W-1:0] miss_cnt,
    input  logic [CNT_W-1:0] acq_len,
    input  logic [CNT_W-1:0] loss_len,
    output logic             present
);
    pr_state_e      state, state_nx;
    logic [CNT_W:0] hit_after;
    logic [CNT_W:0] miss_after;
    logic           acquire;
    logic           lose;

    always_comb begin
        hit_after  = {1'b0, hit_cnt}  + (CNT_W+1)'(1);
        miss_after = {1'b0, miss_cnt} + (CNT_W+1)'(1);
        acquire    = (acq_len == '0) ||
                     (strobe && seen && hit_after >= {1'b0, acq_len});
        lose       = (loss_len != '0) && strobe && !seen &&
                     (miss_after >= {1'b0, loss_len});
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PR_ABSENT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PR_ABSENT:  if (acquire) state_nx = PR_PRESENT;
            PR_PRESENT: if (lose)    state_nx = PR_ABSENT;
            default:    state_nx = PR_ABSENT;
        endcase
    end

    // outputs
    always_comb begin
        present = (state == PR_PRESENT);
    end

    AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present) |-> $past(acq_len == '0 || (strobe && seen))); // R5
    AST_FALL_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present) |-> $past(strobe && !seen && loss_len != '0)); // R7
    AST_LOSS_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (present && loss_len == '0) |=> present); // R8
    AST_ZERO_ACQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!present && acq_len == '0) |=> present); // R6

endmodule

// File: rtl/sync_presence_top.sv
module sync_presence_top
    import sync_det_pkg::*;
#(
    parameter logic [3:0] CMD_ID = 4'hC,
    parameter int         CNT_W  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_strobe,
    input  logic       sync_seen,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output logic       sync_present,
    output logic [1:0] pin_src,
    output logic       ten_lines,
    output logic       video_mute
);
    localparam int ACQ_W      = 3;
    localparam int LOSS_W     = 4;
    localparam int ACQ_SHIFT  = 2;
    localparam int LOSS_SHIFT = 5;

    ctrl_t             ctrl;
    logic [ACQ_W-1:0]  acq_code;
    logic [LOSS_W-1:0] loss_code;
    logic [CNT_W-1:0]  acq_len;
    logic [CNT_W-1:0]  loss_len;
    logic [CNT_W-1:0]  hit_cnt;
    logic [CNT_W-1:0]  miss_cnt;
    logic              hit_ev;
    logic              miss_ev;

    always_comb begin
        hit_ev  = line_strobe && sync_seen;
        miss_ev = line_strobe && !sync_seen;
    end

    sync_cmd_decoder #(.CMD_ID(CMD_ID), .ACQ_W(ACQ_W), .LOSS_W(LOSS_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr), .wr_data(cmd_byte),
        .ctrl(ctrl), .acq_code(acq_code), .loss_code(loss_code)
    );

    sync_thr_decode #(.CODE_W(ACQ_W), .SHIFT(ACQ_SHIFT), .LEN_W(CNT_W)) u_acq_len (
        .code(acq_code), .len(acq_len)
    );

    sync_thr_decode #(.CODE_W(LOSS_W), .SHIFT(LOSS_SHIFT), .LEN_W(CNT_W)) u_loss_len (
        .code(loss_code), .len(loss_len)
    );

    sync_run_counter #(.CNT_W(CNT_W)) u_hit_run (
        .clk(clk), .rst_n(rst_n), .inc(hit_ev), .clr(miss_ev), .cnt(hit_cnt)
    );

    sync_run_counter #(.CNT_W(CNT_W)) u_miss_run (
        .clk(clk), .rst_n(rst_n), .inc(miss_ev), .clr(hit_ev), .cnt(miss_cnt)
    );

    sync_presence_fsm #(.CNT_W(CNT_W)) u_presence (
        .clk(clk), .rst_n(rst_n), .strobe(line_strobe), .seen(sync_seen),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
        .acq_len(acq_len), .loss_len(loss_len), .present(sync_present)
    );

    always_comb begin
        pin_src    = ctrl.src;
        ten_lines  = ctrl.ten_lines;
        video_mute = ctrl.mute;
    end

endmodule

// File: tb/sync_presence_top_tb.sv
`timescale 1ns/1ps
module sync_presence_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_strobe = 1'b0;
    logic       sync_seen = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       sync_present;
    logic [1:0] pin_src;
    logic       ten_lines;
    logic       video_mute;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sync_presence_top u_dut (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .sync_seen(sync_seen),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .sync_present(sync_present),
        .pin_src(pin_src), .ten_lines(ten_lines), .video_mute(video_mute)
    );

    // row: [20:17] requirement, [16:15] kind (0 write, 1 seen run, 2 miss run),
    //      [14:5] byte or run length, [4] flag, [3:0] {pin_src, ten_lines, mute}
    localparam int NV = 42;
    localparam logic [20:0] VEC [NV] = '{
        {4'd2,  2'd0, 10'h0C5, 1'b1, 4'b0101}, // R2 first byte, R6 flag already up
        {4'd4,  2'd0, 10'h011, 1'b1, 4'b0101}, // R4 acq 4, loss 32
        {4'd7,  2'd2, 10'd31,  1'b1, 4'b0101}, // R7 one short
        {4'd7,  2'd2, 10'd1,   1'b0, 4'b0101}, // R7 32 misses
        {4'd5,  2'd1, 10'd3,   1'b0, 4'b0101}, // R5
        {4'd9,  2'd2, 10'd1,   1'b0, 4'b0101}, // R9 miss breaks run
        {4'd9,  2'd1, 10'd3,   1'b0, 4'b0101}, // R9
        {4'd5,  2'd1, 10'd1,   1'b1, 4'b0101}, // R5 4 seen
        {4'd7,  2'd2, 10'd20,  1'b1, 4'b0101}, // R7
        {4'd9,  2'd1, 10'd1,   1'b1, 4'b0101}, // R9 seen breaks miss run
        {4'd9,  2'd2, 10'd31,  1'b1, 4'b0101}, // R9
        {4'd7,  2'd2, 10'd1,   1'b0, 4'b0101}, // R7
        {4'd2,  2'd0, 10'h0CA, 1'b0, 4'b1010}, // R2
        {4'd4,  2'd0, 10'h022, 1'b0, 4'b1010}, // R4 acq 8, loss 64
        {4'd5,  2'd1, 10'd7,   1'b0, 4'b1010}, // R5
        {4'd5,  2'd1, 10'd1,   1'b1, 4'b1010}, // R5 8 seen
        {4'd7,  2'd2, 10'd63,  1'b1, 4'b1010}, // R7
        {4'd7,  2'd2, 10'd1,   1'b0, 4'b1010}, // R7 64 misses
        {4'd2,  2'd0, 10'h0CF, 1'b0, 4'b1111}, // R2
        {4'd4,  2'd0, 10'h044, 1'b0, 4'b1111}, // R4 acq 16, loss 128
        {4'd5,  2'd1, 10'd15,  1'b0, 4'b1111}, // R5
        {4'd5,  2'd1, 10'd1,   1'b1, 4'b1111}, // R5 16 seen
        {4'd7,  2'd2, 10'd127, 1'b1, 4'b1111}, // R7
        {4'd7,  2'd2, 10'd1,   1'b0, 4'b1111}, // R7 128 misses
        {4'd2,  2'd0, 10'h0C0, 1'b0, 4'b0000}, // R2
        {4'd4,  2'd0, 10'h048, 1'b0, 4'b0000}, // R4 acq 16, loss 256
        {4'd5,  2'd1, 10'd15,  1'b0, 4'b0000}, // R5
        {4'd5,  2'd1, 10'd1,   1'b1, 4'b0000}, // R5
        {4'd7,  2'd2, 10'd255, 1'b1, 4'b0000}, // R7
        {4'd7,  2'd2, 10'd1,   1'b0, 4'b0000}, // R7 256 misses
        {4'd2,  2'd0, 10'h0C0, 1'b0, 4'b0000}, // R2
        {4'd10, 2'd0, 10'h033, 1'b0, 4'b0000}, // R10 both fields invalid
        {4'd10, 2'd1, 10'd15,  1'b0, 4'b0000}, // R10 still 16
        {4'd10, 2'd1, 10'd1,   1'b1, 4'b0000}, // R10
        {4'd10, 2'd2, 10'd255, 1'b1, 4'b0000}, // R10 still 256
        {4'd10, 2'd2, 10'd1,   1'b0, 4'b0000}, // R10
        {4'd2,  2'd0, 10'h0C0, 1'b0, 4'b0000}, // R2
        {4'd10, 2'd0, 10'h013, 1'b0, 4'b0000}, // R10 acq 4 taken, loss kept
        {4'd10, 2'd1, 10'd3,   1'b0, 4'b0000}, // R10
        {4'd10, 2'd1, 10'd1,   1'b1, 4'b0000}, // R10
        {4'd10, 2'd2, 10'd255, 1'b1, 4'b0000}, // R10
        {4'd10, 2'd2, 10'd1,   1'b0, 4'b0000}  // R10
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_byte = b;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic run(input logic s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_strobe = 1'b1;
            sync_seen   = s;
            @(negedge clk);
            line_strobe = 1'b0;
        end
    endtask

    function automatic logic [3:0] ctl();
        return {pin_src, ten_lines, video_mute};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1..: got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flag", 32'(sync_present), 0);
        chk("R1 reset ctrl", 32'(ctl()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 zero acquire rises after reset", 32'(sync_present), 1);

        for (int v = 0; v < NV; v++) begin
            logic [20:0] e;
            string tag;
            e = VEC[v];
            if (e[16:15] == 2'd0) wr(e[12:5]);
            else run(e[16:15] == 2'd1, int'(e[14:5]));
            tag = $sformatf("R%0d row %0d flag", e[20:17], v);
            chk(tag, 32'(sync_present), 32'(e[4]));
            tag = $sformatf("R%0d row %0d ctrl", e[20:17], v);
            chk(tag, 32'(ctl()), 32'(e[3:0]));
        end

        // R8: loss off holds the flag through a long miss run
        wr(8'hC0); wr(8'h10);
        run(1'b1, 4);
        chk("R8 acquired", 32'(sync_present), 1);
        run(1'b0, 600);
        chk("R8 loss off", 32'(sync_present), 1);

        // R11: miss counter is at its ceiling; enable loss 256, one miss drops
        wr(8'hC0); wr(8'h48);
        chk("R11 no change without strobe", 32'(sync_present), 1);
        run(1'b0, 1);
        chk("R11 saturated miss run", 32'(sync_present), 0);

        // R3: foreign bytes in idle
        run(1'b1, 16);
        chk("R3 setup", 32'(sync_present), 1);
        wr(8'h5F);
        chk("R3 foreign id ctrl", 32'(ctl()), 0);
        wr(8'h42);
        chk("R3 lone threshold byte ctrl", 32'(ctl()), 0);
        wr(8'hBF);
        chk("R3 foreign high id ctrl", 32'(ctl()), 0);
        run(1'b0, 100);
        chk("R3 loss still 256", 32'(sync_present), 1);

        // R4: bit7-set foreign byte while waiting is skipped
        wr(8'hCA);
        chk("R4 first byte ctrl", 32'(ctl()), 32'(4'b1010));
        wr(8'h91);
        chk("R4 skipped byte ctrl", 32'(ctl()), 32'(4'b1010));
        wr(8'h11);
        run(1'b1, 1);
        run(1'b0, 31);
        chk("R4 loss 32 not yet", 32'(sync_present), 1);
        run(1'b0, 1);
        chk("R4 loss 32 loaded", 32'(sync_present), 0);

        // R1: reset mid-run clears controls and thresholds
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset flag", 32'(sync_present), 0);
        chk("R1 mid-run reset ctrl", 32'(ctl()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 acquire cleared", 32'(sync_present), 1);
        run(1'b0, 600);
        chk("R1 loss cleared", 32'(sync_present), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule